// File: doc/BRIEF.md
# Branch and Loop Condition Unit

This unit sits in the execute stage of a 16-bit processor core and settles short control transfers. For each accepted operation it reports one of two outcomes. The first is whether a conditional jump is taken, evaluated from the carry, zero, sign, overflow and parity flags. The second is whether a count-driven loop transfer is taken, evaluated from the count register and, for two of the loop forms, the zero flag. Fetch redirection and pipeline flushing belong to the surrounding core.

The unit also produces the next instruction pointer. When the transfer is taken, this is the address of the following instruction plus a sign-extended 8-bit self-relative displacement, which gives a reach of about 128 bytes either side. Otherwise it is the address of the following instruction. For the decrementing loop forms it also returns the decremented count and a write enable for it. All results are registered, so they appear one clock after the operation is presented.

Top module: `blc_branch_unit`

## Requirements
- R1: While rst_ni is low and after it rises, valid_o, taken_o and cnt_we_o are 0 until an operation is accepted.
- R2: An operation presented with valid_i=1 at a rising clock edge produces exactly one result with valid_o=1 after that edge and before the next one. With valid_i=0 at an edge, valid_o is 0 after it.
- R3: The flag-test codes compare a single flag, and an odd code takes the complement of the even code below it. Codes 0x00/0x01 test of_i, codes 0x04/0x05 test zf_i, codes 0x08/0x09 test sf_i and codes 0x0A/0x0B test pf_i. In each pair the even code is taken when the flag is 1.
- R4: The unsigned relational codes work as follows. Code 0x02 is taken when cf_i=1 and code 0x03 is its complement. Code 0x06 is taken when cf_i|zf_i=1 and code 0x07 is its complement.
- R5: The signed relational codes work as follows. Code 0x0C is taken when sf_i^of_i=1 and code 0x0D is its complement. Code 0x0E is taken when (sf_i^of_i)|zf_i=1 and code 0x0F is its complement.
- R6: Code 0x12 (plain loop) writes cnt_i-1 and is taken exactly when that new count is nonzero.
- R7: Code 0x11 (loop while equal) and code 0x10 (loop while not equal) write cnt_i-1. They are taken when the new count is nonzero and zf_i is 1 or 0 respectively.
- R8: Code 0x13 (jump if count zero) is taken exactly when cnt_i is 0 and leaves cnt_we_o at 0.
- R9: A taken result gives ip_o = ip_next_i plus disp_i sign-extended, modulo 2^16. A result that is not taken gives ip_o = ip_next_i.
- R10: Codes 0x14 to 0x1F are never taken, do not write the count and return ip_next_i.
- R11: The loop codes 0x10 to 0x12 always assert cnt_we_o, whether or not the transfer is taken. cnt_o wraps from 0 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code (see R3 to R10) |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| pf_i | input | 1 | Parity flag |
| cnt_i | input | 16 | Current count register value |
| ip_next_i | input | 16 | Address of the following instruction |
| disp_i | input | 8 | Signed self-relative displacement |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Transfer taken |
| ip_o | output | 16 | Next instruction pointer |
| cnt_o | output | 16 | Updated count |
| cnt_we_o | output | 1 | Write enable for the updated count |

## Verification
The assertions that look one cycle back assume that op_i, cnt_i and ip_next_i carry known values whenever valid_i is high, and they gate on reset having been released in the previous cycle. The stimulus drives all inputs on the falling edge and holds them through the following rising edge, so each sampled operation is fully defined. The stimulus covers all 32 operation codes against all 32 flag combinations. Counts of 0, 1 and random values exercise the decrement wrap and the zero tests, and directed cases cover the extreme displacements and wrap-around of the instruction pointer.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int OP_W = 5;

  // loop-form codes; codes 0x00..0x0F are flag conditions
  localparam logic [OP_W-1:0] OP_LOOPNZ = 5'h10;
  localparam logic [OP_W-1:0] OP_LOOPZ  = 5'h11;
  localparam logic [OP_W-1:0] OP_LOOP   = 5'h12;
  localparam logic [OP_W-1:0] OP_JCZ    = 5'h13;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } flags_t;
endpackage

// File: rtl/blc_cond_eval.sv
module blc_cond_eval
  import blc_pkg::*;
(
  input  logic [3:0] code_i,
  input  flags_t     flags_i,
  output logic       hit_o
);
  logic base;
  logic lt_s;

  assign lt_s = flags_i.sf ^ flags_i.of;

  // code[3:1] picks the test, code[0] inverts it
  always_comb begin
    unique case (code_i[3:1])
      3'd0: base = flags_i.of;
      3'd1: base = flags_i.cf;
      3'd2: base = flags_i.zf;
      3'd3: base = flags_i.cf | flags_i.zf;
      3'd4: base = flags_i.sf;
      3'd5: base = flags_i.pf;
      3'd6: base = lt_s;
      default: base = lt_s | flags_i.zf;
    endcase
  end

  assign hit_o = base ^ code_i[0];
endmodule

// File: rtl/blc_count_unit.sv
module blc_count_unit
  import blc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic             zf_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             is_cnt_op_o,
  output logic             hit_o,
  output logic             we_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] dec;
  logic             dec_nz;

  assign dec    = cnt_i - CNT_W'(1);
  assign dec_nz = |dec;
  assign cnt_o  = dec;

  always_comb begin
    is_cnt_op_o = 1'b1;
    we_o        = 1'b1;
    hit_o       = 1'b0;
    unique case (op_i)
      OP_LOOPNZ: hit_o = dec_nz & ~zf_i;
      OP_LOOPZ:  hit_o = dec_nz & zf_i;
      OP_LOOP:   hit_o = dec_nz;
      OP_JCZ: begin
        we_o  = 1'b0;
        hit_o = ~|cnt_i;
      end
      default: begin
        is_cnt_op_o = 1'b0;
        we_o        = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/blc_target_gen.sv
module blc_target_gen #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [IP_W-1:0]   ip_next_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              take_i,
  output logic [IP_W-1:0]   ip_o
);
  logic [IP_W-1:0] disp_ext;

  generate
    if (DISP_W >= IP_W) begin : g_trunc
      assign disp_ext = disp_i[IP_W-1:0];
    end else begin : g_sext
      assign disp_ext = {{(IP_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    end
  endgenerate

  // adder sits off the select path; wraps modulo 2^IP_W
  logic [IP_W-1:0] target;
  assign target = ip_next_i + disp_ext;
  assign ip_o   = take_i ? target : ip_next_i;
endmodule

// File: rtl/blc_branch_unit.sv
module blc_branch_unit
  import blc_pkg::*;
#(
  parameter int IP_W   = 16,
  parameter int CNT_W  = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic              cf_i,
  input  logic              zf_i,
  input  logic              sf_i,
  input  logic              of_i,
  input  logic              pf_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [IP_W-1:0]   ip_next_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [IP_W-1:0]   ip_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_we_o
);
  localparam logic [OP_W-1:0] COND_LAST = 5'h0F;

  flags_t           flags;
  logic             cond_hit;
  logic             cnt_op;
  logic             cnt_hit;
  logic             cnt_we;
  logic [CNT_W-1:0] cnt_dec;
  logic             take;
  logic [IP_W-1:0]  ip_sel;

  assign flags = '{cf: cf_i, zf: zf_i, sf: sf_i, of: of_i, pf: pf_i};

  blc_cond_eval u_cond (
    .code_i  (op_i[3:0]),
    .flags_i (flags),
    .hit_o   (cond_hit)
  );

  blc_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .op_i        (op_i),
    .zf_i        (zf_i),
    .cnt_i       (cnt_i),
    .is_cnt_op_o (cnt_op),
    .hit_o       (cnt_hit),
    .we_o        (cnt_we),
    .cnt_o       (cnt_dec)
  );

  always_comb begin
    if (op_i <= COND_LAST) take = cond_hit;
    else if (cnt_op)       take = cnt_hit;
    else                   take = 1'b0;
  end

  blc_target_gen #(.IP_W(IP_W), .DISP_W(DISP_W)) u_tgt (
    .ip_next_i (ip_next_i),
    .disp_i    (disp_i),
    .take_i    (take),
    .ip_o      (ip_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      taken_o  <= 1'b0;
      cnt_we_o <= 1'b0;
      ip_o     <= '0;
      cnt_o    <= '0;
    end else begin
      valid_o  <= valid_i;
      taken_o  <= valid_i & take;
      cnt_we_o <= valid_i & cnt_we;
      if (valid_i) begin
        ip_o  <= ip_sel;
        cnt_o <= cnt_dec;
      end
    end
  end

  // R1 R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!taken_o && !cnt_we_o));

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (valid_o == $past(valid_i)));

  // R11
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && cnt_we_o) |-> (cnt_o == $past(cnt_i) - CNT_W'(1)));

  // R8
  jcz_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && valid_o && $past(op_i) == OP_JCZ)
      |-> (!cnt_we_o && (taken_o == ($past(cnt_i) == '0))));

  // R9
  fallthrough_ip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && valid_o && !taken_o) |-> (ip_o == $past(ip_next_i)));

  // R6
  loop_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o && cnt_we_o) |-> (cnt_o != '0));
endmodule

// File: tb/sim_blc_branch_unit.sv
module sim_blc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic        cf_i = 0, zf_i = 0, sf_i = 0, of_i = 0, pf_i = 0;
  logic [15:0] cnt_i = '0;
  logic [15:0] ip_next_i = '0;
  logic [7:0]  disp_i = '0;
  logic        valid_o, taken_o, cnt_we_o;
  logic [15:0] ip_o, cnt_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int          stamp;
    logic [4:0]  op;
    logic        taken;
    logic [15:0] ip;
    logic [15:0] cnt;
    logic        we;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  blc_branch_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .cf_i(cf_i), .zf_i(zf_i), .sf_i(sf_i), .of_i(of_i), .pf_i(pf_i),
    .cnt_i(cnt_i), .ip_next_i(ip_next_i), .disp_i(disp_i),
    .valid_o(valid_o), .taken_o(taken_o), .ip_o(ip_o),
    .cnt_o(cnt_o), .cnt_we_o(cnt_we_o)
  );

  function automatic string tag_of(logic [4:0] op);
    if (op inside {5'h00, 5'h01, 5'h04, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0B}) return "R3";
    if (op inside {5'h02, 5'h03, 5'h06, 5'h07}) return "R4";
    if (op inside {5'h0C, 5'h0D, 5'h0E, 5'h0F}) return "R5";
    if (op == 5'h12) return "R6";
    if (op == 5'h10 || op == 5'h11) return "R7";
    if (op == 5'h13) return "R8";
    return "R10";
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(logic [4:0] op, logic [4:0] f, logic [15:0] cx,
                                 logic [15:0] ipn, logic [7:0] d);
    exp_t e;
    logic cf, zf, sf, of, pf;
    logic [15:0] nc;
    {cf, zf, sf, of, pf} = f;
    nc = cx - 16'd1;
    e.op = op; e.we = 1'b0; e.cnt = nc; e.taken = 1'b0;
    case (op)
      5'h00: e.taken = of;
      5'h01: e.taken = !of;
      5'h02: e.taken = cf;
      5'h03: e.taken = !cf;
      5'h04: e.taken = zf;
      5'h05: e.taken = !zf;
      5'h06: e.taken = cf || zf;
      5'h07: e.taken = !cf && !zf;
      5'h08: e.taken = sf;
      5'h09: e.taken = !sf;
      5'h0A: e.taken = pf;
      5'h0B: e.taken = !pf;
      5'h0C: e.taken = (sf != of);
      5'h0D: e.taken = (sf == of);
      5'h0E: e.taken = (sf != of) || zf;
      5'h0F: e.taken = (sf == of) && !zf;
      5'h10: begin e.we = 1'b1; e.taken = (nc != 0) && !zf; end
      5'h11: begin e.we = 1'b1; e.taken = (nc != 0) && zf; end
      5'h12: begin e.we = 1'b1; e.taken = (nc != 0); end
      5'h13: e.taken = (cx == 0);
      default: e.taken = 1'b0;
    endcase
    e.ip = e.taken ? (ipn + {{8{d[7]}}, d}) : ipn;
    return e;
  endfunction

  task automatic send(logic [4:0] op, logic [4:0] f, logic [15:0] cx,
                      logic [15:0] ipn, logic [7:0] d);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; {cf_i, zf_i, sf_i, of_i, pf_i} = f;
    cnt_i = cx; ip_next_i = ipn; disp_i = d;
    e = model(op, f, cx, ipn, d);
    e.stamp = cyc;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    op_i = $urandom;
    cnt_i = $urandom;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        if (sb.size() == 0 || sb[0].stamp != cyc - 1) begin
          checks++; errors++;
          $display("FAIL R2 unexpected result: actual valid_o=1 expected valid_o=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          checks++;
          if (taken_o !== e.taken) begin
            errors++;
            $display("FAIL %s op=%h taken: actual %b expected %b", tag_of(e.op), e.op, taken_o, e.taken);
          end
          checks++;
          if (ip_o !== e.ip) begin
            errors++;
            $display("FAIL R9 op=%h ip: actual %h expected %h", e.op, ip_o, e.ip);
          end
          checks++;
          if (cnt_we_o !== e.we || (e.we && cnt_o !== e.cnt)) begin
            errors++;
            $display("FAIL %s op=%h count: actual we=%b cnt=%h expected we=%b cnt=%h",
                     (e.op == 5'h13) ? "R8" : "R11", e.op, cnt_we_o, cnt_o, e.we, e.cnt);
          end
        end
      end else if (sb.size() != 0 && sb[0].stamp == cyc - 1) begin
        exp_t e;
        e = sb.pop_front();
        checks++; errors++;
        $display("FAIL R2 missing result op=%h: actual valid_o=0 expected valid_o=1", e.op);
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    checks++;
    if (valid_o !== 1'b0 || taken_o !== 1'b0 || cnt_we_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: actual %b%b%b expected 000", valid_o, taken_o, cnt_we_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || taken_o !== 1'b0 || cnt_we_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: actual %b%b%b expected 000", valid_o, taken_o, cnt_we_o);
    end

    // directed corners
    send(5'h12, 5'b00000, 16'h0001, 16'h1000, 8'h10);  // R11 count to zero, not taken
    send(5'h12, 5'b00000, 16'h0000, 16'h1000, 8'h10);  // R11 wrap to FFFF, taken
    send(5'h11, 5'b01000, 16'h0002, 16'h2000, 8'hFE);  // R7 taken backwards
    send(5'h10, 5'b01000, 16'h0002, 16'h2000, 8'hFE);  // R7 blocked by zf
    send(5'h13, 5'b00000, 16'h0000, 16'h3000, 8'h7F);  // R8 taken, max forward
    send(5'h13, 5'b00000, 16'h0005, 16'h3000, 8'h7F);  // R8 not taken
    send(5'h04, 5'b01000, 16'h0000, 16'h0100, 8'h80);  // R9 max backward
    send(5'h04, 5'b01000, 16'h0000, 16'hFFFE, 8'h05);  // R9 wrap up
    send(5'h05, 5'b00000, 16'h0000, 16'h0002, 8'hF0);  // R9 wrap down
    send(5'h1F, 5'b11111, 16'h0000, 16'h4000, 8'h20);  // R10
    idle();
    idle();

    // sweep all codes over all flag combinations
    for (int op = 0; op < 32; op++) begin
      for (int f = 0; f < 32; f++) begin
        logic [15:0] cx;
        case (f % 4)
          0: cx = 16'h0001;
          1: cx = 16'h0000;
          default: cx = 16'($urandom);
        endcase
        send(5'(op), 5'(f), cx, 16'($urandom), 8'($urandom));
        if ((f % 7) == 3) idle();
      end
    end
    idle();
    repeat (3) @(negedge clk);
    // R2: all results delivered
    checks++;
    if (sb.size() != 0 || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R2 drain: actual pending=%0d valid_o=%b expected 0 0", sb.size(), valid_o);
    end
    finish_run();
  end
endmodule